// File: doc/BRIEF.md
# Serial Controller Command Port

This block is the host side of the register access path of a two-channel serial communications controller. The host has one write port per channel, and that port always lands on control register 0 of the addressed channel. Control register 0 carries a three-bit command code and a three-bit pointer. A non-zero pointer sends the next write to that channel to the selected register, and the pointer then falls back to zero. Every accepted write is forwarded on a configuration-write output that carries the channel, the register index and the data, so a register file elsewhere can store it.

Commands written to control register 0 turn into one-cycle strobes toward the transmitter, the receiver and the interrupt logic. The command port also holds two request flags per channel: transmit buffer empty, and special receive condition. A channel reset holds further writes to that channel off for a parameterized number of cycles, four by default. A transmit underrun in byte-count mode causes an abort on its own, with no command written.

Top module: `serial_cmd_port`

## Requirements
- R1: After hardware reset every output is low and every channel pointer is 0, so the first write to either channel is forwarded with register index 0.
- R2: A write to register 0 loads the pointer from data bits 2:0. If the loaded value is non-zero, the next accepted write to that channel is forwarded with that index, and the write after that goes to index 0 again.
- R3: Command code 0 (bits 5:3 = 000) only loads the pointer and raises no strobe.
- R4: Command code 1 raises `txAbort` for the addressed channel alone, for exactly the one cycle after the write.
- R5: `txUnderrun` with `byteCountMode` high raises `txAbort` for that channel in the next cycle. `txUnderrun` with `byteCountMode` low has no effect.
- R6: Command code 3 pulses `chanResetOut` for that channel and clears its `txIntReq` and `specialRxInt`. The pointer field of that write is ignored, so the pointer stays 0.
- R7: `prioReset` pulses together with a channel reset of channel 0 (A) and stays low for a reset of channel 1 (B).
- R8: After a channel reset, `chanBusy` for that channel is high for BUSY_CYCLES (4) cycles. Writes to that channel in that window are dropped with no forwarding and no effect, while the other channel keeps accepting writes.
- R9: `txIntReq` is set by `txShiftLoad`, or by `crcFirstSent` when `syncMode` is high, and `crcFirstSent` alone does nothing. Command code 5 clears `txIntReq`. A set in the same cycle as the clear wins.
- R10: Command code 4 pulses `rxIntArm` for the addressed channel.
- R11: `rxSpecial` sets `specialRxInt`. Command code 6 pulses `errResetOut` and clears `specialRxInt`.
- R12: Command codes 2 and 7 raise no strobe and change no flag.
- R13: A write reached through a non-zero pointer decodes no command, whatever its bits 5:3 hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low hardware reset |
| wrEn | input | 1 | Host write strobe |
| wrChan | input | 1 | Addressed channel (0 = A, 1 = B) |
| wrData | input | 8 | Host write data |
| txUnderrun | input | 2 | Per-channel transmit underrun |
| byteCountMode | input | 2 | Per-channel transmit byte-count mode enable |
| syncMode | input | 2 | Per-channel synchronous mode |
| txShiftLoad | input | 2 | Character moved to transmit shift register |
| crcFirstSent | input | 2 | First CRC character sent |
| rxSpecial | input | 2 | Special receive condition detected |
| cfgWrValid | output | 1 | Forwarded register write valid |
| cfgWrChan | output | 1 | Channel of forwarded write |
| cfgWrIdx | output | 3 | Register index of forwarded write |
| cfgWrData | output | 8 | Data of forwarded write |
| txAbort | output | 2 | Per-channel transmit abort strobe |
| chanResetOut | output | 2 | Per-channel reset strobe |
| prioReset | output | 1 | Shared interrupt priority reset strobe |
| rxIntArm | output | 2 | Re-arm first-character receive interrupt |
| errResetOut | output | 2 | Error reset strobe (parity capture re-enable) |
| txIntReq | output | 2 | Transmit buffer empty request pending |
| specialRxInt | output | 2 | Special receive condition interrupt pending |
| chanBusy | output | 2 | Channel held off after reset |

## Verification
The bench sends each command code to each channel. This shows that a strobe comes out on the addressed channel only and only for the matching code, and that the unused codes do nothing. Pointer sequences write a load, then a pointed write whose bits 5:3 hold a command code, then a plain command. These tell a pointer that returns to zero apart from one that sticks, and show whether a pointed write decodes a command. Set and clear pulses on the request flags, including both in one cycle, test the set-over-clear ordering. A channel B reset is followed by writes to both channels inside the hold-off window, and a channel A reset follows, so channel-local effects can be told apart from shared ones.

// File: rtl/serial_cmd_pkg.sv
package serial_cmd_pkg;

  localparam int PTR_W = 3;
  localparam int CMD_LSB = 3;

  typedef enum logic [2:0] {
    CMD_NULL     = 3'd0,
    CMD_ABORT    = 3'd1,
    CMD_SPARE2   = 3'd2,
    CMD_CHRESET  = 3'd3,
    CMD_ARMRX    = 3'd4,
    CMD_CLRTX    = 3'd5,
    CMD_ERRRESET = 3'd6,
    CMD_SPARE7   = 3'd7
  } cmd_e;

  typedef struct packed {
    logic             cfgWr;
    logic [PTR_W-1:0] idx;
    logic             abort;
    logic             chReset;
    logic             armRx;
    logic             clrTxPend;
    logic             errReset;
  } strobe_t;

endpackage

// File: rtl/serial_cmd_ctrl.sv
module serial_cmd_ctrl
  import serial_cmd_pkg::*;
#(
  parameter int NCH = 2,
  parameter int SEL_W = 1,
  parameter int BUSY_CYCLES = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [SEL_W-1:0] wrChan,
  input  logic [5:0]       crField,
  output strobe_t          strobes [NCH],
  output logic [NCH-1:0]   busy
);

  localparam int CNT_W = $clog2(BUSY_CYCLES + 1);

  cmd_e cmdCode;
  assign cmdCode = cmd_e'(crField[CMD_LSB +: 3]);

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    logic [PTR_W-1:0] ptrQ;
    logic [CNT_W-1:0] busyQ;
    logic             accept;
    logic             direct;

    assign accept = wrEn && (wrChan == SEL_W'(c)) && (busyQ == '0);
    assign direct = (ptrQ == '0);
    assign busy[c] = (busyQ != '0);

    always_comb begin
      strobes[c] = '0;
      if (accept) begin
        strobes[c].cfgWr = 1'b1;
        strobes[c].idx   = ptrQ;
        if (direct) begin
          case (cmdCode)
            CMD_ABORT:    strobes[c].abort     = 1'b1;
            CMD_CHRESET:  strobes[c].chReset   = 1'b1;
            CMD_ARMRX:    strobes[c].armRx     = 1'b1;
            CMD_CLRTX:    strobes[c].clrTxPend = 1'b1;
            CMD_ERRRESET: strobes[c].errReset  = 1'b1;
            default:      ;
          endcase
        end
      end
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        ptrQ  <= '0;
        busyQ <= '0;
      end else begin
        if (accept) begin
          if (direct && cmdCode != CMD_CHRESET) ptrQ <= crField[PTR_W-1:0];
          else ptrQ <= '0;
        end
        if (accept && direct && cmdCode == CMD_CHRESET) busyQ <= CNT_W'(BUSY_CYCLES);
        else if (busyQ != '0) busyQ <= busyQ - 1'b1;
      end
    end

    assert_ptr_return_R2: assert property (@(posedge clk) disable iff (!rstN)
      (accept && !direct) |=> (ptrQ == '0));

    assert_reset_holds_R8: assert property (@(posedge clk) disable iff (!rstN)
      strobes[c].chReset |=> busy[c]);

    assert_busy_drop_R8: assert property (@(posedge clk) disable iff (!rstN)
      (busy[c] && wrEn && wrChan == SEL_W'(c)) |=> $stable(ptrQ));

    assert_pointed_nocmd_R13: assert property (@(posedge clk) disable iff (!rstN)
      (accept && !direct) |-> !(strobes[c].abort || strobes[c].chReset ||
        strobes[c].armRx || strobes[c].clrTxPend || strobes[c].errReset));
  end

endmodule

// File: rtl/serial_cmd_dpath.sv
module serial_cmd_dpath
  import serial_cmd_pkg::*;
#(
  parameter int NCH = 2,
  parameter int SEL_W = 1,
  parameter int DW = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          strobes [NCH],
  input  logic [DW-1:0]    wrData,
  input  logic [NCH-1:0]   txUnderrun,
  input  logic [NCH-1:0]   byteCountMode,
  input  logic [NCH-1:0]   syncMode,
  input  logic [NCH-1:0]   txShiftLoad,
  input  logic [NCH-1:0]   crcFirstSent,
  input  logic [NCH-1:0]   rxSpecial,
  output logic             cfgWrValid,
  output logic [SEL_W-1:0] cfgWrChan,
  output logic [PTR_W-1:0] cfgWrIdx,
  output logic [DW-1:0]    cfgWrData,
  output logic [NCH-1:0]   txAbort,
  output logic [NCH-1:0]   chanResetOut,
  output logic             prioReset,
  output logic [NCH-1:0]   rxIntArm,
  output logic [NCH-1:0]   errResetOut,
  output logic [NCH-1:0]   txIntReq,
  output logic [NCH-1:0]   specialRxInt
);

  logic             wrNext;
  logic [SEL_W-1:0] chanNext;
  logic [PTR_W-1:0] idxNext;

  always_comb begin
    wrNext   = 1'b0;
    chanNext = '0;
    idxNext  = '0;
    for (int c = 0; c < NCH; c++) begin
      if (strobes[c].cfgWr) begin
        wrNext   = 1'b1;
        chanNext = SEL_W'(c);
        idxNext  = strobes[c].idx;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgWrValid <= 1'b0;
      cfgWrChan  <= '0;
      cfgWrIdx   <= '0;
      cfgWrData  <= '0;
      prioReset  <= 1'b0;
    end else begin
      cfgWrValid <= wrNext;
      prioReset  <= strobes[0].chReset;
      if (wrNext) begin
        cfgWrChan <= chanNext;
        cfgWrIdx  <= idxNext;
        cfgWrData <= wrData;
      end
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    logic txSet;
    assign txSet = txShiftLoad[c] || (syncMode[c] && crcFirstSent[c]);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        txAbort[c]      <= 1'b0;
        chanResetOut[c] <= 1'b0;
        rxIntArm[c]     <= 1'b0;
        errResetOut[c]  <= 1'b0;
        txIntReq[c]     <= 1'b0;
        specialRxInt[c] <= 1'b0;
      end else begin
        txAbort[c]      <= strobes[c].abort || (txUnderrun[c] && byteCountMode[c]);
        chanResetOut[c] <= strobes[c].chReset;
        rxIntArm[c]     <= strobes[c].armRx;
        errResetOut[c]  <= strobes[c].errReset;
        if (strobes[c].chReset)        txIntReq[c] <= 1'b0;
        else if (txSet)                txIntReq[c] <= 1'b1;
        else if (strobes[c].clrTxPend) txIntReq[c] <= 1'b0;
        if (strobes[c].chReset)        specialRxInt[c] <= 1'b0;
        else if (rxSpecial[c])         specialRxInt[c] <= 1'b1;
        else if (strobes[c].errReset)  specialRxInt[c] <= 1'b0;
      end
    end

    assert_auto_abort_R5: assert property (@(posedge clk) disable iff (!rstN)
      (txUnderrun[c] && byteCountMode[c]) |=> txAbort[c]);

    assert_tx_clear_R9: assert property (@(posedge clk) disable iff (!rstN)
      (strobes[c].clrTxPend && !txSet) |=> !txIntReq[c]);

    assert_reset_flags_R6: assert property (@(posedge clk) disable iff (!rstN)
      strobes[c].chReset |=> (!txIntReq[c] && !specialRxInt[c]));

    assert_err_clear_R11: assert property (@(posedge clk) disable iff (!rstN)
      (strobes[c].errReset && !rxSpecial[c]) |=> !specialRxInt[c]);
  end

  assert_prio_chan_a_R7: assert property (@(posedge clk) disable iff (!rstN)
    prioReset |-> chanResetOut[0]);

endmodule

// File: rtl/serial_cmd_port.sv
module serial_cmd_port
  import serial_cmd_pkg::*;
#(
  parameter int NCH = 2,
  parameter int DW = 8,
  parameter int BUSY_CYCLES = 4,
  localparam int SEL_W = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [SEL_W-1:0] wrChan,
  input  logic [DW-1:0]    wrData,
  input  logic [NCH-1:0]   txUnderrun,
  input  logic [NCH-1:0]   byteCountMode,
  input  logic [NCH-1:0]   syncMode,
  input  logic [NCH-1:0]   txShiftLoad,
  input  logic [NCH-1:0]   crcFirstSent,
  input  logic [NCH-1:0]   rxSpecial,
  output logic             cfgWrValid,
  output logic [SEL_W-1:0] cfgWrChan,
  output logic [2:0]       cfgWrIdx,
  output logic [DW-1:0]    cfgWrData,
  output logic [NCH-1:0]   txAbort,
  output logic [NCH-1:0]   chanResetOut,
  output logic             prioReset,
  output logic [NCH-1:0]   rxIntArm,
  output logic [NCH-1:0]   errResetOut,
  output logic [NCH-1:0]   txIntReq,
  output logic [NCH-1:0]   specialRxInt,
  output logic [NCH-1:0]   chanBusy
);

  strobe_t strobes [NCH];

  serial_cmd_ctrl #(.NCH(NCH), .SEL_W(SEL_W), .BUSY_CYCLES(BUSY_CYCLES)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrChan(wrChan),
    .crField(wrData[5:0]), .strobes(strobes), .busy(chanBusy)
  );

  serial_cmd_dpath #(.NCH(NCH), .SEL_W(SEL_W), .DW(DW)) u_dpath (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wrData(wrData),
    .txUnderrun(txUnderrun), .byteCountMode(byteCountMode), .syncMode(syncMode),
    .txShiftLoad(txShiftLoad), .crcFirstSent(crcFirstSent), .rxSpecial(rxSpecial),
    .cfgWrValid(cfgWrValid), .cfgWrChan(cfgWrChan), .cfgWrIdx(cfgWrIdx),
    .cfgWrData(cfgWrData), .txAbort(txAbort), .chanResetOut(chanResetOut),
    .prioReset(prioReset), .rxIntArm(rxIntArm), .errResetOut(errResetOut),
    .txIntReq(txIntReq), .specialRxInt(specialRxInt)
  );

endmodule

// File: tb/serial_cmd_port_bench.sv
module serial_cmd_port_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rstN = 0, wrEn = 0, wrChan = 0;
  logic [7:0] wrData = 0;
  logic [1:0] txUnderrun = 0, byteCountMode = 0, syncMode = 0;
  logic [1:0] txShiftLoad = 0, crcFirstSent = 0, rxSpecial = 0;
  logic cfgWrValid, cfgWrChan, prioReset;
  logic [2:0] cfgWrIdx;
  logic [7:0] cfgWrData;
  logic [1:0] txAbort, chanResetOut, rxIntArm, errResetOut, txIntReq, specialRxInt, chanBusy;

  serial_cmd_port u_serial_cmd_port (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0;
  logic [11:0] expQ [$];
  logic [2:0] ptrModel [2];

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // monitor: pops scoreboard on each forwarded write
  always @(negedge clk) begin
    if (rstN && cfgWrValid) begin
      if (expQ.size() == 0) check(0, "R8", "unexpected forwarded write", {cfgWrChan, cfgWrIdx, cfgWrData}, 0);
      else begin
        logic [11:0] e;
        e = expQ.pop_front();
        check({cfgWrChan, cfgWrIdx, cfgWrData} == e, "R2", "forwarded write", {cfgWrChan, cfgWrIdx, cfgWrData}, e);
      end
    end
  end

  // driver: one write, scoreboard prediction from the pointer model
  task automatic hostWrite(input logic ch, input logic [7:0] d, input bit drop);
    if (!drop) begin
      logic [2:0] idx;
      idx = ptrModel[ch];
      expQ.push_back({ch, idx, d});
      if (idx == 0) ptrModel[ch] = (d[5:3] == 3'd3) ? 3'd0 : d[2:0];
      else ptrModel[ch] = 3'd0;
    end
    wrEn = 1; wrChan = ch; wrData = d;
    @(posedge clk); @(negedge clk);
    wrEn = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin @(posedge clk); @(negedge clk); end
  endtask

  task automatic noStrobes(input string req);
    check({txAbort, chanResetOut, rxIntArm, errResetOut, prioReset} == 0, req,
          "strobes", {txAbort, chanResetOut, rxIntArm, errResetOut, prioReset}, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    ptrModel[0] = 0; ptrModel[1] = 0;
    @(negedge clk); @(negedge clk);
    check({cfgWrValid, txIntReq, specialRxInt, chanBusy} == 0, "R1", "reset state", {cfgWrValid, txIntReq, specialRxInt, chanBusy}, 0);
    noStrobes("R1");
    rstN = 1;
    @(negedge clk);

    hostWrite(0, 8'h00, 0); noStrobes("R3");                 // R1 first write idx 0
    hostWrite(0, 8'h03, 0); noStrobes("R3");
    hostWrite(0, 8'hAB, 0); noStrobes("R13");                // pointed, bits5:3 = 5
    hostWrite(0, 8'h08, 0);
    check(txAbort == 2'b01, "R4", "abort chan A", txAbort, 1);
    idle(1);
    check(txAbort == 0, "R4", "abort one cycle", txAbort, 0);

    byteCountMode = 2'b10; txUnderrun = 2'b11;
    idle(1); txUnderrun = 0;
    check(txAbort == 2'b10, "R5", "auto abort only in byte-count mode", txAbort, 2);
    idle(1);

    txShiftLoad = 2'b01; idle(1); txShiftLoad = 0;
    check(txIntReq == 2'b01, "R9", "set by shift load", txIntReq, 1);
    hostWrite(0, 8'h28, 0);
    check(txIntReq == 0, "R9", "cleared by code 5", txIntReq, 0);
    crcFirstSent = 2'b01; idle(1); crcFirstSent = 0;
    check(txIntReq == 0, "R9", "crc sent without sync ignored", txIntReq, 0);
    syncMode = 2'b01; crcFirstSent = 2'b01; idle(1); crcFirstSent = 0;
    check(txIntReq == 2'b01, "R9", "crc sent in sync mode", txIntReq, 1);
    txShiftLoad = 2'b01; hostWrite(0, 8'h28, 0); txShiftLoad = 0;
    check(txIntReq == 2'b01, "R9", "set wins over clear", txIntReq, 1);

    hostWrite(1, 8'h20, 0);
    check(rxIntArm == 2'b10, "R10", "arm rx chan B", rxIntArm, 2);
    rxSpecial = 2'b10; idle(1); rxSpecial = 0;
    check(specialRxInt == 2'b10, "R11", "special set", specialRxInt, 2);
    hostWrite(1, 8'h30, 0);
    check(errResetOut == 2'b10, "R11", "error reset strobe", errResetOut, 2);
    check(specialRxInt == 0, "R11", "special cleared", specialRxInt, 0);

    hostWrite(0, 8'h10, 0); noStrobes("R12");
    hostWrite(0, 8'h38, 0); noStrobes("R12");
    check(txIntReq == 2'b01, "R12", "flags unchanged", txIntReq, 1);

    rxSpecial = 2'b10; txShiftLoad = 2'b10; idle(1); rxSpecial = 0; txShiftLoad = 0;
    hostWrite(1, 8'h1D, 0);
    check(chanResetOut == 2'b10, "R6", "reset strobe chan B", chanResetOut, 2);
    check(prioReset == 0, "R7", "no priority reset for B", prioReset, 0);
    check(txIntReq == 2'b01 && specialRxInt == 0, "R6", "B flags cleared", {txIntReq, specialRxInt}, 4);
    check(chanBusy == 2'b10, "R8", "busy after reset", chanBusy, 2);
    hostWrite(1, 8'h0F, 1);
    check(txAbort == 0, "R8", "dropped write no abort", txAbort, 0);
    hostWrite(0, 8'h00, 0);                                   // other channel accepted
    hostWrite(1, 8'h0F, 1);
    check(chanBusy == 2'b10, "R8", "still busy", chanBusy, 2);
    hostWrite(1, 8'h0F, 1);
    check(chanBusy == 0, "R8", "busy ends after 4 cycles", chanBusy, 0);
    hostWrite(1, 8'h00, 0);                                   // idx 0: pointer untouched
    hostWrite(0, 8'h18, 0);
    check(chanResetOut == 2'b01 && prioReset, "R7", "priority reset with A", {chanResetOut, prioReset}, 3);
    idle(6);
    check(expQ.size() == 0, "R2", "scoreboard drained", expQ.size(), 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule